// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the execute slice of a small processor: seven general registers, two operand multiplexers, an arithmetic and logic unit, a destination decoder and a status flag register. Every clock cycle an external controller presents one 14-bit control word. The word chooses the two operands, the operation and the register that receives the result.

The unit result is always visible on the result port, in the same cycle as the control word. Writing a register is optional. Source code zero takes the operand from the external data input, and destination code zero writes nothing. The result port and the input port are the only way in and out of the register file.

Carry, sign, zero and overflow flags are registered from the unit result at each rising edge. An unrecognised operation code yields a zero result and leaves the flags unchanged.

Top module: `cw_datapath`

## Requirements
- R1: The control word packs four fields. Bits 13:11 hold the A-operand select, bits 10:8 the B-operand select, bits 7:5 the destination select and bits 4:0 the operation code.
- R2: An operand select of 1 to 7 reads the register of that number. An operand select of 0 reads `data_i`.
- R3: A destination select of 1 to 7 loads that register with the result at the rising clock edge. Destination 0 loads no register. `result_o` always carries the combinational result of the current control word.
- R4: Arithmetic operation codes, all modulo 2^DATA_W: 00001 gives A+1, 00010 gives A+B, 00101 gives A-B, 00110 gives A-1.
- R5: Pass and logic operation codes: 00000 gives A, 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, 01110 gives NOT A.
- R6: Operation 10000 shifts A right by one and 11000 shifts A left by one. The vacated bit is filled with 0.
- R7: Carry is the adder carry out. Subtract is computed as A + NOT B + 1, so carry 1 means no borrow. Decrement is computed as A plus all ones, so its carry is 1 exactly when A is nonzero. On a shift, carry takes the bit shifted out. Pass, logic and complement operations clear carry and overflow.
- R8: The flags are registered at the rising edge from the result of that cycle. Sign is the result MSB. Zero is 1 when every result bit is 0.
- R9: Overflow is the carry into the result MSB XOR the carry out of the MSB. This is signed overflow for add, subtract, increment and decrement. Shifts clear overflow.
- R10: Any operation code not listed in R4 to R6 gives a zero result, which is loaded into a nonzero destination. It leaves all four flags unchanged.
- R11: Reset clears all seven registers and all four flags.
- R12: A control word that names one register as A source, B source and destination, with operation XOR, clears that register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 14 | Control word |
| data_i | input | DATA_W | External operand, read when a source select is 0 |
| result_o | output | DATA_W | Unit result for the current control word |
| carry_o | output | 1 | Registered carry flag |
| sign_o | output | 1 | Registered sign flag |
| zero_o | output | 1 | Registered zero flag |
| ovf_o | output | 1 | Registered overflow flag |

## Verification
`result_o` is due in the same cycle as its control word. A destination write becomes visible to a later control word after one rising edge. The flags for that word appear after the same edge. The bench drives each control word 1 ns after a rising edge and compares the result at the following falling edge. It compares the flags one full cycle later, at the next falling edge, so every sample is taken well away from the edge that produced it.

// File: rtl/cwd_pkg.sv
`timescale 1ns/1ps
package cwd_pkg;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned OP_W   = 5;
  localparam int unsigned CTRL_W = 3 * SEL_W + OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_PASS = 5'b00000,
    OP_INC  = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_SUB  = 5'b00101,
    OP_DEC  = 5'b00110,
    OP_AND  = 5'b01000,
    OP_OR   = 5'b01010,
    OP_XOR  = 5'b01100,
    OP_NOT  = 5'b01110,
    OP_SHR  = 5'b10000,
    OP_SHL  = 5'b11000
  } alu_op_e;

  typedef struct packed {
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] dst;
    logic [OP_W-1:0]  op;
  } ctrl_word_t;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flags_t;
endpackage

// File: rtl/cwd_regfile.sv
`timescale 1ns/1ps
module cwd_regfile #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd_a_sel_i,
  input  logic [SEL_W-1:0]  rd_b_sel_i,
  input  logic [DATA_W-1:0] ext_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o
);
  localparam int unsigned NSLOT = 1 << SEL_W;

  logic [DATA_W-1:0] regs [1:NSLOT-1];

  // slot 0 is the external bus; only slots 1..NSLOT-1 hold state
  for (genvar g = 1; g < NSLOT; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       regs[g] <= '0;
      else if (wr_sel_i == SEL_W'(g))    regs[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_a_o = (rd_a_sel_i == '0) ? ext_i : regs[rd_a_sel_i];
    rd_b_o = (rd_b_sel_i == '0) ? ext_i : regs[rd_b_sel_i];
  end
endmodule

// File: rtl/cwd_alu.sv
`timescale 1ns/1ps
module cwd_alu
  import cwd_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o,
  output logic              op_ok_o
);
  logic [DATA_W-1:0] add_y;
  logic              add_ci;
  logic              use_add;
  logic [DATA_W-1:0] lo;
  logic [1:0]        hi;
  logic [DATA_W-1:0] sum;
  logic              c_msb_in;
  logic              c_out;
  logic              sh_c;

  // operand steering for the shared adder
  always_comb begin
    add_y   = '0;
    add_ci  = 1'b0;
    use_add = 1'b1;
    case (op_i)
      OP_INC: begin add_y = '0;  add_ci = 1'b1; end
      OP_ADD: begin add_y = b_i; add_ci = 1'b0; end
      OP_SUB: begin add_y = ~b_i; add_ci = 1'b1; end
      OP_DEC: begin add_y = '1;  add_ci = 1'b0; end
      default: use_add = 1'b0;
    endcase
  end

  // split adder exposes the carry into the MSB
  assign lo       = {1'b0, a_i[DATA_W-2:0]} + {1'b0, add_y[DATA_W-2:0]} + DATA_W'(add_ci);
  assign c_msb_in = lo[DATA_W-1];
  assign hi       = {1'b0, a_i[DATA_W-1]} + {1'b0, add_y[DATA_W-1]} + {1'b0, c_msb_in};
  assign c_out    = hi[1];
  assign sum      = {hi[0], lo[DATA_W-2:0]};

  always_comb begin
    res_o   = '0;
    sh_c    = 1'b0;
    op_ok_o = 1'b1;
    case (op_i)
      OP_PASS: res_o = a_i;
      OP_INC, OP_ADD, OP_SUB, OP_DEC: res_o = sum;
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_NOT:  res_o = ~a_i;
      OP_SHR:  begin res_o = {1'b0, a_i[DATA_W-1:1]}; sh_c = a_i[0]; end
      OP_SHL:  begin res_o = {a_i[DATA_W-2:0], 1'b0}; sh_c = a_i[DATA_W-1]; end
      default: op_ok_o = 1'b0;
    endcase
  end

  always_comb begin
    flags_o.c = use_add ? c_out : sh_c;
    flags_o.v = use_add & (c_out ^ c_msb_in);
    flags_o.s = res_o[DATA_W-1];
    flags_o.z = (res_o == '0);
  end
endmodule

// File: rtl/cwd_status.sv
`timescale 1ns/1ps
module cwd_status
  import cwd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   upd_i,
  input  flags_t flags_i,
  output flags_t flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_o <= '0;
    else if (upd_i) flags_o <= flags_i;
  end
endmodule

// File: rtl/cw_datapath.sv
`timescale 1ns/1ps
module cw_datapath
  import cwd_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [13:0]       ctrl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              sign_o,
  output logic              zero_o,
  output logic              ovf_o
);
  ctrl_word_t        cw;
  logic [DATA_W-1:0] bus_a;
  logic [DATA_W-1:0] bus_b;
  logic [DATA_W-1:0] alu_res;
  flags_t            alu_flags;
  flags_t            flags_q;
  logic              op_ok;

  assign cw = ctrl_word_t'(ctrl_i[CTRL_W-1:0]);

  cwd_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_sel_i   (cw.dst),
    .wr_data_i  (alu_res),
    .rd_a_sel_i (cw.src_a),
    .rd_b_sel_i (cw.src_b),
    .ext_i      (data_i),
    .rd_a_o     (bus_a),
    .rd_b_o     (bus_b)
  );

  cwd_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i     (bus_a),
    .b_i     (bus_b),
    .op_i    (cw.op),
    .res_o   (alu_res),
    .flags_o (alu_flags),
    .op_ok_o (op_ok)
  );

  cwd_status u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (op_ok),
    .flags_i (alu_flags),
    .flags_o (flags_q)
  );

  assign result_o = alu_res;
  assign carry_o  = flags_q.c;
  assign sign_o   = flags_q.s;
  assign zero_o   = flags_q.z;
  assign ovf_o    = flags_q.v;
endmodule

// File: rtl/cw_datapath_chk.sv
`timescale 1ns/1ps
module cw_datapath_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [13:0]       ctrl_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              sign_o,
  input logic              zero_o,
  input logic              ovf_o
);
  logic       past_ok;
  logic [2:0] src_a;
  logic [2:0] dst;
  logic [4:0] op;
  logic [3:0] flg;

  assign src_a = ctrl_i[13:11];
  assign dst   = ctrl_i[7:5];
  assign op    = ctrl_i[4:0];
  assign flg   = {carry_o, sign_o, zero_o, ovf_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  function automatic logic known(logic [4:0] o);
    case (o)
      5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110, 5'b01000,
      5'b01010, 5'b01100, 5'b01110, 5'b10000, 5'b11000: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic logic_op(logic [4:0] o);
    return (o == 5'b00000) || (o == 5'b01000) || (o == 5'b01010) ||
           (o == 5'b01100) || (o == 5'b01110);
  endfunction

  AST_WRITE_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && op == 5'b00000 && src_a != 3'd0 && src_a == $past(dst))
    |-> result_o == $past(result_o)); // R3

  AST_NO_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && op == 5'b00000 && $past(op) == 5'b00000 && src_a != 3'd0 &&
     $past(src_a) == src_a && $past(dst) == 3'd0)
    |-> $stable(result_o)); // R3

  AST_BAD_OP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known(op) |-> result_o == '0); // R10

  AST_BAD_OP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known(op) |=> $stable(flg)); // R10

  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    known(op) |=> zero_o == ($past(result_o) == '0)); // R8

  AST_SIGN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    known(op) |=> sign_o == $past(result_o[DATA_W-1])); // R8

  AST_LOGIC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logic_op(op) |=> (!carry_o && !ovf_o)); // R7
endmodule

bind cw_datapath cw_datapath_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ctrl_i   (ctrl_i),
  .result_o (result_o),
  .carry_o  (carry_o),
  .sign_o   (sign_o),
  .zero_o   (zero_o),
  .ovf_o    (ovf_o)
);

// File: tb/cw_datapath_bench.sv
`timescale 1ns/1ps
module cw_datapath_bench;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] res;
    logic [3:0]   flg;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [13:0]  ctrl = '0;
  logic [W-1:0] din = '0;
  logic [W-1:0] res;
  logic         c_o, s_o, z_o, v_o;

  int errors = 0;
  int checks = 0;
  exp_t q[$];
  logic [W-1:0] m_reg [1:7];
  logic [3:0]   m_flg;

  always #2.5 clk = ~clk;

  cw_datapath #(.DATA_W(W)) u_cw_datapath (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .data_i(din),
    .result_o(res), .carry_o(c_o), .sign_o(s_o), .zero_o(z_o), .ovf_o(v_o)
  );

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: computes expectation from the requirements, pushes it
  task automatic run(input logic [2:0] a, input logic [2:0] b, input logic [2:0] d,
                     input logic [4:0] op, input logic [W-1:0] data, input string req);
    logic [W-1:0] av, bv, r;
    logic [W:0]   t;
    logic         c, v, ok;
    exp_t e;
    @(posedge clk); #1;
    ctrl = {a, b, d, op};  // R1 packing
    din  = data;
    av = (a == 3'd0) ? data : m_reg[a];
    bv = (b == 3'd0) ? data : m_reg[b];
    c = 1'b0; v = 1'b0; ok = 1'b1; r = '0;
    case (op)
      5'b00000: r = av;
      5'b00001: begin t = {1'b0, av} + 1;   r = t[W-1:0]; c = t[W]; v = (av == {1'b0, {(W-1){1'b1}}}); end
      5'b00010: begin t = {1'b0, av} + {1'b0, bv}; r = t[W-1:0]; c = t[W];
                      v = (av[W-1] == bv[W-1]) && (r[W-1] != av[W-1]); end
      5'b00101: begin t = {1'b0, av} + {1'b0, ~bv} + 1; r = t[W-1:0]; c = t[W];
                      v = (av[W-1] != bv[W-1]) && (r[W-1] != av[W-1]); end
      5'b00110: begin r = av - 1; c = (av != '0); v = (av == {1'b1, {(W-1){1'b0}}}); end
      5'b01000: r = av & bv;
      5'b01010: r = av | bv;
      5'b01100: r = av ^ bv;
      5'b01110: r = ~av;
      5'b10000: begin r = av >> 1; c = av[0]; end
      5'b11000: begin r = av << 1; c = av[W-1]; end
      default:  ok = 1'b0;
    endcase
    if (ok) m_flg = {c, r[W-1], (r == '0), v};
    if (d != 3'd0) m_reg[d] = r;
    e.res = r; e.flg = m_flg; e.req = req;
    q.push_back(e);
  endtask

  // monitor: result mid-cycle, flags one cycle later
  initial begin
    exp_t cur;
    bit pend = 0;
    forever begin
      @(negedge clk);
      if (pend) begin
        chk(cur.req, "flags{c,s,z,v}", W'({c_o, s_o, z_o, v_o}), W'(cur.flg));
        pend = 0;
      end
      if (q.size() > 0) begin
        cur = q.pop_front();
        chk(cur.req, "result", res, cur.res);
        pend = 1;
      end
    end
  end

  initial begin
    #20000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 1; i <= 7; i++) m_reg[i] = '0;
    m_flg = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "flags after reset", W'({c_o, s_o, z_o, v_o}), '0);
    // R11: registers read back as zero
    for (int i = 1; i <= 7; i++) run(3'(i), 3'd0, 3'd0, 5'b00000, 8'h5A, "R11");
    // R2 R3: load registers from external input
    run(3'd0, 3'd0, 3'd1, 5'b00000, 8'h7F, "R2");
    run(3'd0, 3'd0, 3'd2, 5'b00000, 8'h80, "R2");
    run(3'd0, 3'd0, 3'd3, 5'b00000, 8'hFF, "R2");
    run(3'd0, 3'd0, 3'd4, 5'b00000, 8'h01, "R2");
    run(3'd0, 3'd0, 3'd5, 5'b00000, 8'hA5, "R2");
    run(3'd0, 3'd0, 3'd6, 5'b00000, 8'h3C, "R2");
    run(3'd0, 3'd0, 3'd7, 5'b00000, 8'h00, "R2");
    for (int i = 1; i <= 7; i++) run(3'(i), 3'd0, 3'd0, 5'b00000, 8'h11, "R3");
    // R4 R9: arithmetic with carry and overflow corners
    run(3'd1, 3'd4, 3'd0, 5'b00010, 8'h00, "R9");   // 7F+01 overflow
    run(3'd3, 3'd4, 3'd0, 5'b00010, 8'h00, "R7");   // FF+01 carry, zero
    run(3'd2, 3'd3, 3'd0, 5'b00010, 8'h00, "R9");   // 80+FF overflow
    run(3'd1, 3'd0, 3'd0, 5'b00001, 8'h00, "R4");   // 7F+1
    run(3'd3, 3'd0, 3'd0, 5'b00001, 8'h00, "R4");   // FF+1
    run(3'd2, 3'd4, 3'd0, 5'b00101, 8'h00, "R9");   // 80-01 overflow
    run(3'd4, 3'd3, 3'd0, 5'b00101, 8'h00, "R7");   // 01-FF borrow
    run(3'd5, 3'd5, 3'd0, 5'b00101, 8'h00, "R4");   // equal
    run(3'd2, 3'd0, 3'd0, 5'b00110, 8'h00, "R9");   // dec 80
    run(3'd7, 3'd0, 3'd0, 5'b00110, 8'h00, "R7");   // dec 00
    run(3'd0, 3'd6, 3'd0, 5'b00010, 8'h11, "R2");   // input on A
    run(3'd6, 3'd0, 3'd0, 5'b00101, 8'h3C, "R2");   // input on B
    // R5 R7: logic ops clear C and V
    run(3'd5, 3'd6, 3'd0, 5'b01000, 8'h00, "R5");
    run(3'd5, 3'd6, 3'd0, 5'b01010, 8'h00, "R5");
    run(3'd5, 3'd6, 3'd0, 5'b01100, 8'h00, "R5");
    run(3'd5, 3'd0, 3'd0, 5'b01110, 8'h00, "R5");
    // R6: shifts
    run(3'd5, 3'd0, 3'd0, 5'b10000, 8'h00, "R6");
    run(3'd2, 3'd0, 3'd0, 5'b11000, 8'h00, "R6");
    run(3'd4, 3'd0, 3'd0, 5'b10000, 8'h00, "R6");
    // R3: write a computed result, then read it
    run(3'd1, 3'd4, 3'd6, 5'b00010, 8'h00, "R3");
    run(3'd6, 3'd0, 3'd0, 5'b00000, 8'h00, "R3");
    // R3: destination 0 writes nothing
    run(3'd4, 3'd4, 3'd0, 5'b01100, 8'h00, "R3");
    run(3'd4, 3'd0, 3'd0, 5'b00000, 8'h00, "R3");
    // R12: self XOR clears the register
    run(3'd5, 3'd5, 3'd5, 5'b01100, 8'h00, "R12");
    run(3'd5, 3'd0, 3'd0, 5'b00000, 8'h00, "R12");
    // R10: unlisted codes give zero, write zero, hold flags
    run(3'd3, 3'd0, 3'd0, 5'b00001, 8'h00, "R10"); // sets carry and zero
    run(3'd1, 3'd2, 3'd1, 5'b00011, 8'h00, "R10");
    run(3'd1, 3'd0, 3'd0, 5'b00000, 8'h00, "R10");
    run(3'd2, 3'd0, 3'd0, 5'b11111, 8'h00, "R10");
    run(3'd2, 3'd0, 3'd0, 5'b00111, 8'h00, "R10");
    run(3'd2, 3'd0, 3'd0, 5'b00000, 8'h00, "R8");
    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule